// File: doc/BRIEF.md
# Configurable-Sense Interrupt Collector

This block gathers up to 32 interrupt sources into two interrupt request lines: one for urgent (critical) service and one for ordinary (non-critical) service. Each source is synchronised to the local clock. It is then conditioned by its own polarity setting and its own sense setting, either level or edge, and any event it produces is held in a pending register. Software configures and services the block through a small synchronous register bus. It clears pending events by writing ones. A per-source enable masks the pending register, and a per-source route bit steers each enabled pending source to one of the two request lines.

Several instances can be chained. The non-critical line of a child instance drives one source input of a parent instance. Software services the child first and then clears the parent's pending bit for that input. Because that parent input is normally configured as level-sensitive, it re-latches at once if the child still has work pending.

Top module: `intc_unit`

## Requirements
- R1: Source n (input `irq_src[n]`) occupies bit (31 − n) of every register, so source 0 is register bit 31 and source 31 is bit 0.
- R2: After reset the enable (address 1), route (address 2), polarity (address 3) and sense (address 4) registers read zero, the masked view reads zero and both request outputs are low.
- R3: A write to address 1, 2, 3 or 4 stores the full 32-bit write data, and a later read of that address returns it.
- R4: With its sense bit at 0 (level), a source sets its pending bit in every cycle in which it is active. Its polarity bit at 1 makes it active high, and at 0 makes it active low.
- R5: With its sense bit at 1 (edge), a source sets its pending bit once per transition: a rising transition when its polarity bit is 1, a falling transition when its polarity bit is 0. The opposite transition and a steady input set nothing.
- R6: Writing to address 0 clears each pending bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. No other action clears a pending bit.
- R7: When a clear hits a level-sensitive source that is still active, the clear takes effect in that cycle, the bit reads 0 for exactly one read, and the bit is set again on the following cycle.
- R8: Address 5 reads the bitwise AND of the pending and enable registers. Writes to address 5 change no register.
- R9: The critical output is high one cycle after any source is pending, enabled and has its route bit at 1. The non-critical output is high one cycle after any source is pending, enabled and has its route bit at 0.
- R10: Read data is registered: the value for an address appears in the cycle after the address is presented. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select (0 pending, 1 enable, 2 route, 3 polarity, 4 sense, 5 masked view) |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 32 | Raw asynchronous interrupt sources, bit n is source n |
| irq_crit | output | 1 | Registered critical interrupt request |
| irq_noncrit | output | 1 | Registered non-critical interrupt request |

## Verification
The checker watches several things on every cycle. Both request lines must follow the pending, enable and route state one cycle later. A pending bit may drop only in the cycle after a write to the pending register. Enable writes must land intact, the masked view must read back as the AND of pending and enable, and the unused addresses must read zero. Some behaviour depends on input history, so only the bench's directed scenarios can show it: the active-low and active-high level sense, rising versus falling edge selection, an edge source that does not re-latch while a held level source does after a one-read gap, and the MSB-first placement of each source.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND  = 3'd0,
    REG_EN    = 3'd1,
    REG_ROUTE = 3'd2,
    REG_POL   = 3'd3,
    REG_SENSE = 3'd4,
    REG_MASK  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] sense_edge,
  output logic [W-1:0] evt
);
  logic [W-1:0] active;
  logic [W-1:0] active_prev_q;
  logic [W-1:0] edge_hit;

  // polarity 1: input high is active; polarity 0: input low is active
  assign active = ~(sync_in ^ pol);

  always_ff @(posedge clk) begin
    if (rst) active_prev_q <= '0;
    else     active_prev_q <= active;
  end

  assign edge_hit = active & ~active_prev_q;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign evt[b] = sense_edge[b] ? edge_hit[b] : active[b];
    end
  endgenerate
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] masked,
  input  logic [W-1:0] route_crit,
  output logic         req_crit,
  output logic         req_noncrit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_crit    <= 1'b0;
      req_noncrit <= 1'b0;
    end else begin
      req_crit    <= |(masked & route_crit);
      req_noncrit <= |(masked & ~route_crit);
    end
  end
endmodule

// File: rtl/intc_unit.sv
module intc_unit
  import intc_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      irq_src,
  output logic              irq_crit,
  output logic              irq_noncrit
);
  localparam int unsigned MSB = W - 1;

  reg_sel_e     sel;
  logic [W-1:0] src_msb;
  logic [W-1:0] src_sync;
  logic [W-1:0] evt;
  logic [W-1:0] stat_q, en_q, crit_q, pol_q, trig_q;
  logic [W-1:0] clr_mask;
  logic [W-1:0] masked;

  assign sel = reg_sel_e'(bus_addr);

  // source n lands on register bit MSB-n
  genvar n;
  generate
    for (n = 0; n < W; n++) begin : g_map
      assign src_msb[MSB-n] = irq_src[n];
    end
  endgenerate

  intc_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_msb),
    .q   (src_sync)
  );

  intc_detect #(.W(W)) i_detect (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (src_sync),
    .pol        (pol_q),
    .sense_edge (trig_q),
    .evt        (evt)
  );

  assign clr_mask = (bus_we && sel == REG_PEND) ? bus_wdata : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (bus_we) begin
      case (sel)
        REG_EN:    en_q   <= bus_wdata;
        REG_ROUTE: crit_q <= bus_wdata;
        REG_POL:   pol_q  <= bus_wdata;
        REG_SENSE: trig_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // pending register: a clear beats a level event in the same cycle,
  // while an edge event is never lost to a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | (evt & ~(clr_mask & ~trig_q));
  end

  assign masked = stat_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        REG_PEND:  bus_rdata <= stat_q;
        REG_EN:    bus_rdata <= en_q;
        REG_ROUTE: bus_rdata <= crit_q;
        REG_POL:   bus_rdata <= pol_q;
        REG_SENSE: bus_rdata <= trig_q;
        REG_MASK:  bus_rdata <= masked;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  intc_route #(.W(W)) i_route (
    .clk         (clk),
    .rst         (rst),
    .masked      (masked),
    .route_crit  (crit_q),
    .req_crit    (irq_crit),
    .req_noncrit (irq_noncrit)
  );
endmodule

// File: rtl/intc_unit_chk.sv
module intc_unit_chk
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              irq_crit,
  input logic              irq_noncrit,
  input logic [W-1:0]      stat_q,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      crit_q
);
  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> (en_q == '0 && crit_q == '0 && !irq_crit && !irq_noncrit));

  assert_crit_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & en_q & crit_q)) |=> irq_crit);

  assert_crit_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & en_q & crit_q)) |=> !irq_crit);

  assert_noncrit_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & en_q & ~crit_q)) |=> irq_noncrit);

  assert_noncrit_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & en_q & ~crit_q)) |=> !irq_noncrit);

  assert_pend_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == REG_PEND) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_en_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == REG_EN) |=> (en_q == $past(bus_wdata)));

  assert_masked_read_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_MASK) |=> (bus_rdata == $past(stat_q & en_q)));

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > REG_MASK) |=> (bus_rdata == '0));
endmodule

bind intc_unit intc_unit_chk #(.W(W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_crit    (irq_crit),
  .irq_noncrit (irq_noncrit),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .crit_q      (crit_q)
);

// File: tb/test_intc_unit.sv
module test_intc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  localparam logic [2:0] A_PEND = 3'd0, A_EN = 3'd1, A_ROUTE = 3'd2,
                         A_POL = 3'd3, A_SENSE = 3'd4, A_MASK = 3'd5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  irq_src = '1;
  logic          irq_crit, irq_noncrit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t cur;
  logic [31:0] act;

  intc_unit i_intc_unit (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_src     (irq_src),
    .irq_crit    (irq_crit),
    .irq_noncrit (irq_noncrit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] bit_of(int src);
    return 32'h1 << (31 - src);
  endfunction

  // monitor: compare every expected item in the cycle it falls due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      cur = sb_q.pop_front();
      act = cur.is_out ? {30'b0, irq_crit, irq_noncrit} : bus_rdata;
      tests++;
      if (act !== cur.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.due = cyc + 1; it.is_out = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_out(bit crit, bit nc, string tag);
    item_t it;
    it.due = cyc + 1; it.is_out = 1'b1; it.exp = {30'b0, crit, nc}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R2: reset state
    rd(A_EN, 0, "R2 enable");
    rd(A_ROUTE, 0, "R2 route");
    rd(A_POL, 0, "R2 polarity");
    rd(A_SENSE, 0, "R2 sense");
    rd(A_MASK, 0, "R2 masked");
    chk_out(0, 0, "R2 outputs");
    // R10: unused address
    rd(3'd6, 0, "R10 unused addr");
    // R6: clear all, inputs idle (active low, held high)
    idle(4);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, 0, "R6 clear all");
    // R3: readback of route register
    wr(A_ROUTE, 32'h1234_5678);
    rd(A_ROUTE, 32'h1234_5678, "R3 route readback");
    wr(A_ROUTE, 0);
    // R1/R4: source 0 active-low level -> bit 31
    irq_src[0] = 1'b0;
    idle(4);
    rd(A_PEND, bit_of(0), "R1 R4 source0 bit31");
    rd(A_MASK, 0, "R8 disabled masked");
    chk_out(0, 0, "R9 disabled no request");
    wr(A_EN, bit_of(0));
    idle(2);
    rd(A_MASK, bit_of(0), "R8 masked source0");
    chk_out(0, 1, "R9 noncritical route");
    wr(A_ROUTE, bit_of(0));
    idle(2);
    chk_out(1, 0, "R9 critical route");
    // R6: writing zero has no effect
    wr(A_PEND, 0);
    rd(A_PEND, bit_of(0), "R6 zero write");
    // R7: level re-latch after one-read gap
    wr(A_PEND, bit_of(0));
    rd(A_PEND, 0, "R7 gap read");
    rd(A_PEND, bit_of(0), "R7 relatched");
    // release and clear
    irq_src[0] = 1'b1;
    idle(4);
    wr(A_PEND, bit_of(0));
    idle(1);
    rd(A_PEND, 0, "R6 cleared after release");
    chk_out(0, 0, "R9 idle after clear");
    // R5: source 5 rising edge
    wr(A_POL, bit_of(5));
    rd(A_POL, bit_of(5), "R3 polarity readback");
    wr(A_SENSE, bit_of(5));
    irq_src[5] = 1'b0;
    idle(4);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, 0, "R5 setup clear");
    irq_src[5] = 1'b1;
    idle(4);
    rd(A_PEND, bit_of(5), "R5 rising edge");
    wr(A_PEND, bit_of(5));
    idle(3);
    rd(A_PEND, 0, "R5 edge no relatch");
    irq_src[5] = 1'b0;
    idle(4);
    rd(A_PEND, 0, "R5 falling ignored");
    // R5: source 7 falling edge
    wr(A_SENSE, bit_of(5) | bit_of(7));
    rd(A_SENSE, bit_of(5) | bit_of(7), "R3 sense readback");
    idle(3);
    rd(A_PEND, 0, "R5 steady no event");
    irq_src[7] = 1'b0;
    idle(4);
    rd(A_PEND, bit_of(7), "R5 falling edge");
    irq_src[7] = 1'b1;
    idle(4);
    rd(A_PEND, bit_of(7), "R5 rising ignored held");
    // R8/R9: masking and routing
    rd(A_MASK, 0, "R8 masked off");
    chk_out(0, 0, "R9 masked no request");
    wr(A_EN, bit_of(0) | bit_of(7));
    idle(2);
    rd(A_MASK, bit_of(7), "R8 masked source7");
    chk_out(0, 1, "R9 source7 noncritical");
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_EN, bit_of(0) | bit_of(7), "R8 readonly enable kept");
    rd(A_MASK, bit_of(7), "R8 readonly masked kept");
    irq_src[0] = 1'b0;
    idle(4);
    chk_out(1, 1, "R9 both requests");
    idle(3);
    if (sb_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule